// File: doc/BRIEF.md
# Multi-Tap Circular Echo Delay

This block adds echo to a stream of signed 24-bit audio samples. It keeps a circular history of past samples in an internal memory, one word per sample period. The memory depth is a parameter, so a small depth can stand in for a long one. It runs on a bit-rate clock that ticks 48 times per sample period and has its own frame counter. In each frame it stores the new sample, then fetches five earlier samples in turn. The spacing between these taps grows exponentially with an 8-bit Time code. It weights the taps and adds them to the dry sample.

Three 8-bit codes shape the echo. Mix sets the level of the first tap, and every later tap is half as loud as the tap before it. Repeats decides how many of the five taps are heard. Time sets the distance between taps. A single enable input turns the effect off, and the dry sample is then passed through. The history keeps filling while the effect is off, so turning it back on brings the echo back at once.

Top module: `echo_tap_delay`

## Requirements
- R1: A frame is 48 clocks long and starts at the first rising edge after reset is released. The input controls and sample are captured at the frame's first edge. `sample_o` changes only at the frame's 17th edge (edge index 16). `sample_valid_o` is high for exactly the one clock that follows that edge.
- R2: The captured sample is stored at a base pointer, and the pointer advances by one every frame. Only bits [23:8] are stored. A tap value read back is that 16-bit word with eight zero bits appended below it.
- R3: Tap k (k = 1..5) reads the sample stored (k·S mod DEPTH) frames before the current one. The current frame's own sample counts as distance 0.
- R4: The step S is round(2605 · 1.0161845455^T), taken modulo DEPTH, where T is the Time code 0..255.
- R5: Each tap takes three clocks: an address cycle, a wait cycle for the memory, and a scaling cycle.
- R6: With M the Mix code, the gain is A = floor(64·M/255). Tap k contributes floor(v·A / 2^(5+k)), where v is the re-expanded 24-bit tap value. Mix 0 gives no echo.
- R7: The number of audible taps is 1 + floor(4·R/255), where R is the Repeats code, counted from tap 1 upward. Code 0 keeps only tap 1, code 64 adds tap 2, and code 255 enables all five.
- R8: A tap whose distance reaches back past the samples written since reset reads as zero.
- R9: The dry sample and all audible contributions are summed without loss. The sum is then saturated to the range −8388608..8388607.
- R10: With enable low at the frame's first edge, the frame's output equals that frame's captured input. The sample is still written to the history.
- R11: During and right after reset, `sample_o` is 0 and `sample_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, 48 ticks per frame |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | 1 applies the echo, 0 passes the dry sample |
| time_i | input | 8 | Tap spacing code |
| repeats_i | input | 8 | Number of audible taps code |
| mix_i | input | 8 | Level of the first tap |
| sample_i | input | 24 | Signed input sample, captured at frame start |
| sample_o | output | 24 | Signed output sample, updated once per frame |
| sample_valid_o | output | 1 | One-clock pulse when `sample_o` changes |

## Verification
Most faults inside the block show up as a wrong output word in the same frame, 17 clocks after the sample is captured. A wrong tap gain, mute count or saturation bound appears this way. A misaligned frame sequencer moves or stretches the valid pulse, and this also shows in that same frame. A fault in the base pointer, the step table or the history-fill count is different: it stays hidden until a tap actually reaches the corrupted entry. That can take from a few frames up to the memory depth in frames. Because of this, the stimulus runs long enough to fill and wrap the history, and it sweeps Time over its whole range.

// File: rtl/echo_pkg.sv
package echo_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_READ,
    ST_WAIT,
    ST_SCALE,
    ST_EMIT,
    ST_IDLE
  } seq_state_e;

  // tap spacing in samples for a Time code, rounded to nearest
  function automatic int step_samples(int code);
    real v;
    v = 2605.0;
    for (int i = 0; i < code; i++) v = v * 1.0161845455;
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/echo_step_lut.sv
module echo_step_lut import echo_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] code_i,
  output logic [ADDR_W-1:0] step_o
);
  localparam int ENTRIES = 1 << CTRL_W;

  logic [ADDR_W-1:0] lut [ENTRIES];

  // power-of-two depth: truncation is the modulo
  for (genvar g = 0; g < ENTRIES; g++) begin : g_lut
    assign lut[g] = ADDR_W'(step_samples(g));
  end

  assign step_o = lut[code_i];
endmodule

// File: rtl/echo_sample_mem.sv
module echo_sample_mem #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/echo_tap_scale.sv
module echo_tap_scale #(
  parameter int DATA_W    = 24,
  parameter int STORE_W   = 16,
  parameter int GAIN_FRAC = 6,
  parameter int TAP_W     = 3,
  parameter int ACC_W     = 28
) (
  input  logic [STORE_W-1:0]     word_i,
  input  logic [GAIN_FRAC:0]     gain_i,
  input  logic [TAP_W-1:0]       tap_idx_i,
  input  logic                   active_i,
  output logic signed [ACC_W-1:0] contrib_o
);
  localparam int PAD    = DATA_W - STORE_W;
  localparam int PROD_W = DATA_W + GAIN_FRAC + 2;

  logic signed [DATA_W-1:0] expanded;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    expanded = $signed({word_i, {PAD{1'b0}}});
    prod     = expanded * $signed({1'b0, gain_i});
    // tap 0 is scaled by gain alone, each later tap halves again
    shifted  = prod >>> (GAIN_FRAC + int'(tap_idx_i));
    contrib_o = active_i ? ACC_W'(shifted) : '0;
  end
endmodule

// File: rtl/echo_tap_delay.sv
module echo_tap_delay import echo_pkg::*; #(
  parameter int DATA_W      = 24,
  parameter int STORE_W     = 16,
  parameter int ADDR_W      = 10,
  parameter int TAPS        = 5,
  parameter int CTRL_W      = 8,
  parameter int GAIN_FRAC   = 6,
  parameter int FRAME_TICKS = 48
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enable_i,
  input  logic [CTRL_W-1:0]        time_i,
  input  logic [CTRL_W-1:0]        repeats_i,
  input  logic [CTRL_W-1:0]        mix_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] sample_o,
  output logic                     sample_valid_o
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int TICK_W   = $clog2(FRAME_TICKS);
  localparam int TAP_W    = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int FILL_W   = ADDR_W + 1;
  localparam int GAIN_W   = GAIN_FRAC + 1;
  localparam int ACC_W    = DATA_W + $clog2(TAPS + 1) + 1;
  localparam int CTRL_MAX = (1 << CTRL_W) - 1;

  localparam logic signed [DATA_W-1:0] OUT_HI = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] OUT_LO = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0]  ACC_HI = ACC_W'(OUT_HI);
  localparam logic signed [ACC_W-1:0]  ACC_LO = ACC_W'(OUT_LO);

  seq_state_e               state_q;
  logic [TICK_W-1:0]        tick_q;
  logic [TAP_W-1:0]         tap_q;
  logic [ADDR_W-1:0]        base_q;
  logic [ADDR_W-1:0]        dist_q;
  logic [FILL_W-1:0]        fill_q;
  logic [CTRL_W-1:0]        time_q, rep_q, mix_q;
  logic                     en_q;
  logic signed [DATA_W-1:0] dry_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic [STORE_W-1:0]       word_q;
  logic                     hist_ok_q;

  logic [ADDR_W-1:0]        step_w;
  logic [ADDR_W-1:0]        dist_nxt;
  logic [ADDR_W-1:0]        rd_addr;
  logic [STORE_W-1:0]       rd_data;
  logic                     hist_ok_c;
  logic [GAIN_W-1:0]        gain_c;
  logic                     tap_on_c;
  logic signed [ACC_W-1:0]  contrib_w;
  logic signed [DATA_W-1:0] sat_c;

  echo_step_lut #(
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W)
  ) u_lut (
    .code_i (time_q),
    .step_o (step_w)
  );

  echo_sample_mem #(
    .ADDR_W (ADDR_W),
    .WORD_W (STORE_W)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (state_q == ST_LOAD),
    .waddr_i (base_q),
    .wdata_i (sample_i[DATA_W-1 -: STORE_W]),
    .re_i    (state_q == ST_READ),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  echo_tap_scale #(
    .DATA_W    (DATA_W),
    .STORE_W   (STORE_W),
    .GAIN_FRAC (GAIN_FRAC),
    .TAP_W     (TAP_W),
    .ACC_W     (ACC_W)
  ) u_scale (
    .word_i    (word_q),
    .gain_i    (gain_c),
    .tap_idx_i (tap_q),
    .active_i  (tap_on_c),
    .contrib_o (contrib_w)
  );

  always_comb begin
    dist_nxt  = dist_q + step_w;
    rd_addr   = base_q - dist_nxt;
    // distance 0 is the sample written this frame, always present
    hist_ok_c = {1'b0, dist_nxt} < fill_q;
    gain_c    = GAIN_W'((int'(mix_q) << GAIN_FRAC) / CTRL_MAX);
    tap_on_c  = int'(tap_q) < ((int'(rep_q) * (TAPS - 1)) / CTRL_MAX + 1);
    if (acc_q > ACC_HI)      sat_c = OUT_HI;
    else if (acc_q < ACC_LO) sat_c = OUT_LO;
    else                     sat_c = DATA_W'(acc_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_LOAD;
      tick_q         <= '0;
      tap_q          <= '0;
      base_q         <= '0;
      dist_q         <= '0;
      fill_q         <= '0;
      time_q         <= '0;
      rep_q          <= '0;
      mix_q          <= '0;
      en_q           <= 1'b0;
      dry_q          <= '0;
      acc_q          <= '0;
      word_q         <= '0;
      hist_ok_q      <= 1'b0;
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else begin
      tick_q         <= (tick_q == TICK_W'(FRAME_TICKS - 1)) ? '0 : tick_q + 1'b1;
      sample_valid_o <= 1'b0;
      unique case (state_q)
        ST_LOAD: begin
          dry_q   <= sample_i;
          acc_q   <= ACC_W'(sample_i);
          time_q  <= time_i;
          rep_q   <= repeats_i;
          mix_q   <= mix_i;
          en_q    <= enable_i;
          tap_q   <= '0;
          dist_q  <= '0;
          if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
          state_q <= ST_READ;
        end
        ST_READ: begin
          dist_q    <= dist_nxt;
          hist_ok_q <= hist_ok_c;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          word_q  <= hist_ok_q ? rd_data : '0;
          state_q <= ST_SCALE;
        end
        ST_SCALE: begin
          acc_q <= acc_q + contrib_w;
          if (tap_q == TAP_W'(TAPS - 1)) begin
            state_q <= ST_EMIT;
          end else begin
            tap_q   <= tap_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_EMIT: begin
          sample_o       <= en_q ? sat_c : dry_q;
          sample_valid_o <= 1'b1;
          base_q         <= base_q + 1'b1;
          state_q        <= ST_IDLE;
        end
        default: begin
          if (tick_q == TICK_W'(FRAME_TICKS - 1)) state_q <= ST_LOAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/echo_tap_delay_chk.sv
module echo_tap_delay_chk import echo_pkg::*; #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 10,
  parameter int TICK_W = 6,
  parameter int TAPS   = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_valid_o,
  input logic signed [DATA_W-1:0] sample_o,
  input seq_state_e               state_q,
  input logic [TICK_W-1:0]        tick_q,
  input logic [ADDR_W-1:0]        base_q,
  input logic [ADDR_W:0]          fill_q,
  input logic                     en_q,
  input logic signed [DATA_W-1:0] dry_q
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_valid_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> tick_q == TICK_W'(3 * TAPS + 2));

  assert_valid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  assert_out_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> $stable(sample_o));

  assert_base_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> base_q == ADDR_W'($past(base_q) + 1'b1));

  assert_read_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_READ |=> state_q == ST_WAIT);

  assert_wait_scale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |=> state_q == ST_SCALE);

  assert_fill_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= (ADDR_W + 1)'(DEPTH));

  assert_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && !en_q) |-> sample_o == dry_q);
endmodule

bind echo_tap_delay echo_tap_delay_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .TICK_W (TICK_W),
  .TAPS   (TAPS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_o (sample_valid_o),
  .sample_o       (sample_o),
  .state_q        (state_q),
  .tick_q         (tick_q),
  .base_q         (base_q),
  .fill_q         (fill_q),
  .en_q           (en_q),
  .dry_q          (dry_q)
);

// File: tb/sim_echo_tap_delay.sv
module sim_echo_tap_delay;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int FT    = 48;
  localparam int NF    = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] t_c = '0, r_c = '0, m_c = '0;
  logic signed [23:0] smp = '0;
  logic signed [23:0] out_w;
  logic vld_w;

  always #5 clk = ~clk;

  echo_tap_delay u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .enable_i       (en),
    .time_i         (t_c),
    .repeats_i      (r_c),
    .mix_i          (m_c),
    .sample_i       (smp),
    .sample_o       (out_w),
    .sample_valid_o (vld_w)
  );

  int checks = 0;
  int fails  = 0;
  int mem_m [DEPTH];
  int base_m = 0;
  int fill_m = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] xs(logic [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int bench_step(int t);
    real v;
    v = 2605.0;
    for (int i = 0; i < t; i++) v = v * 1.0161845455;
    return $rtoi(v + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_frame(input int s, input bit e, input int t, input int r,
                             input int m, output int y);
    longint acc, v;
    int a, n, st, d;
    mem_m[base_m] = s >>> 8;
    if (fill_m < DEPTH) fill_m++;
    if (!e) begin
      y = s;
    end else begin
      acc = s;
      a   = (64 * m) / 255;
      n   = 1 + (4 * r) / 255;
      st  = bench_step(t) % DEPTH;
      for (int k = 1; k <= 5; k++) begin
        d = (k * st) % DEPTH;
        if (k <= n && d < fill_m) begin
          v = longint'(mem_m[(base_m - d + DEPTH) % DEPTH]) * 256;
          acc += (v * a) >>> (5 + k);
        end
      end
      if (acc > 8388607) acc = 8388607;
      if (acc < -8388608) acc = -8388608;
      y = int'(acc);
    end
    base_m = (base_m + 1) % DEPTH;
  endtask

  task automatic run_all();
    int prev, y, s, t, r, m;
    bit e;
    string tag;
    longint exp_o;
    repeat (3) @(negedge clk);
    check(vld_w == 1'b0, "R11", "valid in reset", vld_w, 0);
    check(out_w == 0, "R11", "sample in reset", out_w, 0);
    rst_n = 1'b1;
    prev = 0;
    for (int f = 0; f < NF; f++) begin
      rng = xs(rng);
      s = $signed(rng[23:0]);
      t = int'(rng[31:24]);
      rng = xs(rng);
      r = int'(rng[7:0]);
      m = int'(rng[15:8]);
      e = 1'b1;
      if (f < 8) begin
        tag = "R8"; t = 0; r = 255; m = 255; s = (f == 0) ? 256000 : 0;
      end else if (f < 200) begin
        tag = "R3";
      end else if (f < 400) begin
        tag = "R4"; t = (f * 7) % 256; r = 255; m = 255;
      end else if (f < 500) begin
        tag = "R2"; r = 255; m = 255;
      end else if (f < 560) begin
        tag = "R10"; e = 1'b0;
      end else if (f < 600) begin
        tag = "R6"; m = 0; r = 255;
      end else if (f < 1100) begin
        tag = "R7"; m = 255;
      end else if (f < 1300) begin
        tag = "R9"; t = 0; r = 255; m = 255; s = 8388607;
      end else begin
        tag = "R9"; t = 0; r = 255; m = 255; s = -8388608;
      end
      model_frame(s, e, t, r, m, y);
      smp = 24'(s); en = e; t_c = 8'(t); r_c = 8'(r); m_c = 8'(m);
      for (int j = 0; j < FT; j++) begin
        @(posedge clk);
        @(negedge clk);
        check(vld_w == (j == 16), "R1 R5", "valid", vld_w, (j == 16));
        exp_o = (j >= 16) ? y : prev;
        check(out_w == exp_o, tag, "sample", out_w, exp_o);
        if (f == 0 && j == 16) check(out_w == 256000, "R8", "empty history", out_w, 256000);
      end
      prev = y;
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule